// File: doc/BRIEF.md
# Dual-Channel Priority Interrupt Arbiter

This block takes several 32-line banks of interrupt state and picks a winning line for each of two channels: a normal channel and a fast channel. For each line the block receives a pending bit, a mask bit, a route bit and a priority value. Each channel filters its own candidates and chooses the most urgent one. It then raises a request toward the processor and holds the winning line number in a register.

Once a channel has fired, its request and its latched code stay fixed until software re-arms that channel. Software can therefore read the code while new interrupts arrive. A re-arm drops the request. At the next clock edge the channel arbitrates again on the inputs present then.

The bank count and the priority width are parameters.

Top module: `dual_prio_arbiter`

## Requirements
- R1: After reset both requests are low, both latched codes are 0, and both channels are armed.
- R2: A line is a candidate for a channel only when its pending bit is 1, its mask bit is 0 and its route bit selects that channel (route 1 = fast channel, route 0 = normal channel).
- R3: Among the candidates of a channel, the line with the smallest priority value wins; 0 is the most urgent.
- R4: When several candidates share the smallest priority value, the one with the largest global line number wins.
- R5: The latched code is the global line number: bank index times 32 plus bit position. Line k of the flattened inputs is bank k/32, bit k%32.
- R6: When a channel is armed, has at least one candidate and the global enable is 1, then at the next clock edge the block disarms the channel, latches the winner code and raises the request.
- R7: While a channel's request is high and no re-arm is given, the request stays high and the code holds. This holds even when pending, mask or route inputs change.
- R8: A re-arm pulse for a channel lowers that channel's request at the next edge and arms the channel. The channel can fire again one edge later.
- R9: With the global enable at 0 no channel fires. Armed channels wait and fire once the enable returns.
- R10: The two channels arbitrate, fire and re-arm independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendIn | input | NUM_BANKS*32 | Pending bit per line |
| maskIn | input | NUM_BANKS*32 | Mask bit per line, 1 blocks the line |
| routeIn | input | NUM_BANKS*32 | 1 routes the line to the fast channel, 0 to the normal channel |
| prioIn | input | NUM_BANKS*32*PRIO_W | Priority per line, line k at bits k*PRIO_W upward |
| globalEn | input | 1 | Global enable for firing |
| rearmNorm | input | 1 | Re-arm pulse for the normal channel |
| rearmFast | input | 1 | Re-arm pulse for the fast channel |
| reqNorm | output | 1 | Normal channel request |
| reqFast | output | 1 | Fast channel request |
| codeNorm | output | $clog2(NUM_BANKS*32) | Latched normal winner line number |
| codeFast | output | $clog2(NUM_BANKS*32) | Latched fast winner line number |

## Verification
The winner search is combinational and ends in a register. A channel that is armed and enabled therefore shows its request and code one rising edge after the inputs that create a candidate. A re-arm shows as a low request one edge after the pulse. A fresh firing follows one further edge later. The bench changes inputs on falling edges and samples on the next falling edge after each edge counted this way. In that check window it expects the request low right after a re-arm and the expected winner one cycle later. After the pending bits are disturbed, it expects either an unchanged code or a newly fired winner.

// File: rtl/dual_prio_arbiter_pkg.sv
package dual_prio_arbiter_pkg;
  localparam int CHANNELS = 2;   // index 0 normal, index 1 fast
  localparam int BANK_LINES = 32;

  typedef struct packed {
    logic [CHANNELS-1:0] load;   // capture winner code for channel
  } arbStrobe_t;
endpackage

// File: rtl/dual_prio_arbiter_dp.sv
module dual_prio_arbiter_dp
  import dual_prio_arbiter_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PRIO_W    = 6,
  localparam int LINES    = NUM_BANKS * BANK_LINES,
  localparam int CODE_W   = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LINES-1:0]        pendIn,
  input  logic [LINES-1:0]        maskIn,
  input  logic [LINES-1:0]        routeIn,
  input  logic [LINES*PRIO_W-1:0] prioIn,
  input  arbStrobe_t              strobe,
  output logic [CHANNELS-1:0]     anyCand,
  output logic [CODE_W-1:0]       codeQ [CHANNELS]
);

  logic [CODE_W-1:0] winCode [CHANNELS];

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [LINES-1:0]  cand;
    logic [PRIO_W-1:0] bestPrio;
    logic              found;
    logic [CODE_W-1:0] bestIdx;

    assign cand = pendIn & ~maskIn & ((ch == 1) ? routeIn : ~routeIn);

    // Ascending scan with <= makes the highest index win on ties.
    always_comb begin
      found    = 1'b0;
      bestPrio = '0;
      bestIdx  = '0;
      for (int i = 0; i < LINES; i++) begin
        if (cand[i] && (!found || prioIn[i*PRIO_W +: PRIO_W] <= bestPrio)) begin
          found    = 1'b1;
          bestPrio = prioIn[i*PRIO_W +: PRIO_W];
          bestIdx  = CODE_W'(i);
        end
      end
    end

    assign anyCand[ch] = found;
    assign winCode[ch] = bestIdx;

    always_ff @(posedge clk) begin
      if (!rstN)                codeQ[ch] <= '0;
      else if (strobe.load[ch]) codeQ[ch] <= winCode[ch];
    end
  end

endmodule

// File: rtl/dual_prio_arbiter_ctl.sv
module dual_prio_arbiter_ctl
  import dual_prio_arbiter_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                globalEn,
  input  logic [CHANNELS-1:0] rearm,
  input  logic [CHANNELS-1:0] anyCand,
  output arbStrobe_t          strobe,
  output logic [CHANNELS-1:0] reqQ
);

  logic [CHANNELS-1:0] armedQ;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    assign strobe.load[ch] = !rearm[ch] && armedQ[ch] && anyCand[ch] && globalEn;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        armedQ[ch] <= 1'b1;
        reqQ[ch]   <= 1'b0;
      end else if (rearm[ch]) begin
        armedQ[ch] <= 1'b1;
        reqQ[ch]   <= 1'b0;
      end else if (strobe.load[ch]) begin
        armedQ[ch] <= 1'b0;
        reqQ[ch]   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dual_prio_arbiter.sv
module dual_prio_arbiter
  import dual_prio_arbiter_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PRIO_W    = 6,
  localparam int LINES    = NUM_BANKS * BANK_LINES,
  localparam int CODE_W   = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LINES-1:0]        pendIn,
  input  logic [LINES-1:0]        maskIn,
  input  logic [LINES-1:0]        routeIn,
  input  logic [LINES*PRIO_W-1:0] prioIn,
  input  logic                    globalEn,
  input  logic                    rearmNorm,
  input  logic                    rearmFast,
  output logic                    reqNorm,
  output logic                    reqFast,
  output logic [CODE_W-1:0]       codeNorm,
  output logic [CODE_W-1:0]       codeFast
);

  arbStrobe_t          strobe;
  logic [CHANNELS-1:0] anyCand;
  logic [CHANNELS-1:0] reqQ;
  logic [CODE_W-1:0]   codeQ [CHANNELS];

  dual_prio_arbiter_dp #(.NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W)) dp_i (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .maskIn(maskIn),
    .routeIn(routeIn), .prioIn(prioIn), .strobe(strobe),
    .anyCand(anyCand), .codeQ(codeQ)
  );

  dual_prio_arbiter_ctl ctl_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn),
    .rearm({rearmFast, rearmNorm}), .anyCand(anyCand),
    .strobe(strobe), .reqQ(reqQ)
  );

  assign reqNorm  = reqQ[0];
  assign reqFast  = reqQ[1];
  assign codeNorm = codeQ[0];
  assign codeFast = codeQ[1];

endmodule

// File: rtl/dual_prio_arbiter_chk.sv
module dual_prio_arbiter_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              globalEn,
  input logic              rearmNorm,
  input logic              rearmFast,
  input logic              reqNorm,
  input logic              reqFast,
  input logic [CODE_W-1:0] codeNorm,
  input logic [CODE_W-1:0] codeFast
);

  p_hold_norm_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqNorm && !rearmNorm) |=> (reqNorm && $stable(codeNorm)));
  p_hold_fast_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqFast && !rearmFast) |=> (reqFast && $stable(codeFast)));

  p_drop_norm_r8: assert property (@(posedge clk) disable iff (!rstN)
    rearmNorm |=> !reqNorm);
  p_drop_fast_r8: assert property (@(posedge clk) disable iff (!rstN)
    rearmFast |=> !reqFast);

  p_gate_norm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn && !reqNorm) |=> !reqNorm);
  p_gate_fast_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn && !reqFast) |=> !reqFast);

  p_rise_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(reqNorm) || $rose(reqFast)) |-> $past(globalEn));

endmodule

bind dual_prio_arbiter dual_prio_arbiter_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rstN(rstN), .globalEn(globalEn),
  .rearmNorm(rearmNorm), .rearmFast(rearmFast),
  .reqNorm(reqNorm), .reqFast(reqFast),
  .codeNorm(codeNorm), .codeFast(codeFast)
);

// File: tb/dual_prio_arbiter_tb_top.sv
module dual_prio_arbiter_tb_top;
  localparam int NB = 2;
  localparam int PW = 6;
  localparam int L  = NB * 32;
  localparam int CW = $clog2(L);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [L-1:0] pend = '0, mask = '1, route = '0;
  logic [PW-1:0] prio [L];
  logic [L*PW-1:0] prioFlat;
  logic globalEn = 1'b1, rearmNorm = 1'b0, rearmFast = 1'b0;
  logic reqNorm, reqFast;
  logic [CW-1:0] codeNorm, codeFast;

  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < L; i++) prioFlat[i*PW +: PW] = prio[i];

  dual_prio_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .pendIn(pend), .maskIn(mask), .routeIn(route),
    .prioIn(prioFlat), .globalEn(globalEn), .rearmNorm(rearmNorm),
    .rearmFast(rearmFast), .reqNorm(reqNorm), .reqFast(reqFast),
    .codeNorm(codeNorm), .codeFast(codeFast)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int ch, output logic any, output int code);
    int best = 0;
    any = 1'b0;
    code = 0;
    for (int i = 0; i < L; i++) begin
      if (pend[i] && !mask[i] && (route[i] == ch[0])) begin
        if (!any || int'(prio[i]) <= best) begin
          any = 1'b1;
          best = int'(prio[i]);
          code = i;
        end
      end
    end
  endfunction

  // Re-arm both channels, then check drop (R8) and the fresh winners.
  task automatic round(string tag);
    logic aN, aF;
    int cN, cF;
    @(negedge clk); rearmNorm = 1'b1; rearmFast = 1'b1;
    @(negedge clk); rearmNorm = 1'b0; rearmFast = 1'b0;
    check("R8 norm drop", int'(reqNorm), 0);
    check("R8 fast drop", int'(reqFast), 0);
    model(0, aN, cN);
    model(1, aF, cF);
    @(negedge clk);
    check({tag, " R6 norm req"}, int'(reqNorm), int'(aN && globalEn));
    check({tag, " R6 fast req"}, int'(reqFast), int'(aF && globalEn));
    if (aN && globalEn) check({tag, " R3 norm code"}, int'(codeNorm), cN);
    if (aF && globalEn) check({tag, " R3 fast code"}, int'(codeFast), cF);
  endtask

  task automatic randomize_inputs(int prioMod);
    for (int i = 0; i < L; i++) begin
      pend[i]  = ($urandom % 4) == 0;
      mask[i]  = ($urandom % 3) == 0;
      route[i] = $urandom % 2;
      prio[i]  = PW'($urandom % prioMod);
    end
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic aN, aF, pN, pF;
    int cN, cF, sN, sF;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < L; i++) prio[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reqNorm", int'(reqNorm), 0);
    check("R1 reqFast", int'(reqFast), 0);
    check("R1 codeNorm", int'(codeNorm), 0);
    check("R1 codeFast", int'(codeFast), 0);

    // R1 armed at reset: a candidate fires without any re-arm
    pend[7] = 1'b1; mask[7] = 1'b0;
    @(negedge clk);
    check("R1 armed fire", int'(reqNorm), 1);
    check("R5 code 7", int'(codeNorm), 7);

    // R4 tie: lines 3 and 40 equal priority -> 40 (bank 1 bit 8, R5)
    pend = '0; mask = '1;
    pend[3] = 1; mask[3] = 0; pend[40] = 1; mask[40] = 0;
    round("R4 tie");
    check("R4 tie winner", int'(codeNorm), 40);

    // R3 smaller value wins over higher index
    prio[40] = 6'd5; prio[3] = 6'd2;
    round("R3 prio");
    check("R3 prio winner", int'(codeNorm), 3);

    // R2 + R10: line 3 masked, line 20 fast, line 40 normal
    mask[3] = 1; pend[20] = 1; mask[20] = 0; route[20] = 1;
    round("R2 R10");
    check("R2 norm winner", int'(codeNorm), 40);
    check("R10 fast winner", int'(codeFast), 20);

    // R9: enable low blocks, then firing once enabled
    globalEn = 1'b0;
    round("R9 off");
    check("R9 blocked", int'(reqNorm), 0);
    globalEn = 1'b1;
    @(negedge clk);
    check("R9 resumes norm", int'(reqNorm), 1);
    check("R9 resumes fast", int'(reqFast), 1);

    // R10: re-arm only normal, fast stays put
    @(negedge clk); rearmNorm = 1'b1;
    @(negedge clk); rearmNorm = 1'b0;
    check("R10 fast untouched", int'(reqFast), 1);
    check("R8 norm low", int'(reqNorm), 0);

    // Random rounds with R7 hold checks
    for (int t = 0; t < 300; t++) begin
      randomize_inputs((t % 2) ? 4 : 64);
      round("rnd");
      pN = reqNorm; pF = reqFast; sN = int'(codeNorm); sF = int'(codeFast);
      for (int i = 0; i < L; i++) if (($urandom % 3) == 0) pend[i] = ~pend[i];
      model(0, aN, cN);
      model(1, aF, cF);
      @(negedge clk);
      if (pN) begin
        check("R7 norm hold req", int'(reqNorm), 1);
        check("R7 norm hold code", int'(codeNorm), sN);
      end else begin
        check("R6 norm late", int'(reqNorm), int'(aN));
        if (aN) check("R3 norm late code", int'(codeNorm), cN);
      end
      if (pF) begin
        check("R7 fast hold req", int'(reqFast), 1);
        check("R7 fast hold code", int'(codeFast), sF);
      end else begin
        check("R6 fast late", int'(reqFast), int'(aF));
        if (aF) check("R3 fast late code", int'(codeFast), cF);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule